// File: doc/BRIEF.md
# Shader Instruction Ordering Hazard Detector

This block watches a stream of decoded shader instructions, one descriptor per valid cycle, and finds the instruction orderings between scalar memory, vector memory, LDS, scalar ALU and vector ALU work that the hardware does not interlock. When the instruction now presented would complete such a pattern, the block raises `hold` and reports two things. The first is which hazard was found. The second is which kind of mitigating instruction must be inserted ahead of the current one.

Each hazard class has one tracker. A tracker holds a pending flag and, where the class needs one, the scalar register index or buffer address that was recorded. The instruction that opens a pattern sets the tracker. An instruction that mitigates the pattern clears it, and so does the acknowledge of a report.

While `hold` is high the stream is stalled and the descriptor must stay unchanged. Each `ack` pulse retires the hazard that is being reported. The next hazard found on the same instruction, if there is one, then appears. When no hazard remains, the instruction is accepted at the next clock edge.

Top module: `shader_hazard_guard`

Class codes on `in_class`:

| Code | Class |
|------|-------|
| 0 | program control, including scalar NOP |
| 1 | scalar ALU, not program control |
| 2 | branch |
| 3 | scalar memory load |
| 4 | scalar memory store |
| 5 | vector ALU |
| 6 | vector compare |
| 7 | lane permute |
| 8 | vector NOP |
| 9 | vector memory, global or scratch |
| 10 | flat |
| 11 | LDS (DS) |
| 12 | set-vector-skip |
| 13 | version |
| 14 | counter wait |
| 15 | other non-vector |

Classes 5 to 8 are vector ALU instructions. Every other class is non-vector.

Wait kinds on `wait_kind`, used only with class 14:

| Code | Wait kind |
|------|-----------|
| 0 | none |
| 1 | vector-memory count |
| 2 | LGKM count |
| 3 | vector-store count |
| 4 | dependency counter |

## Requirements
- R1: A class 9, 10 or 11 instruction that reads scalar register X, followed later by a class 1 or class 3 instruction that writes X, gives `hz_code`=1 and `mitig`=1 (vector ALU). Any class 5 to 8 instruction in between clears the tracker. A class 14 vector-memory wait with value 0 also clears it.
- R2: A class 3 or class 4 instruction that reads scalar register X, followed later by a vector ALU instruction that writes X, gives `hz_code`=2 and `mitig`=2 (scalar ALU). A class 1 instruction clears the tracker, and so does a class 14 LGKM wait of any value. Classes 0, 12 and 13 do not clear it, and neither does a class 14 wait of another kind.
- R3: A class 6 compare, followed later by a class 7 permute, gives `hz_code`=3 and `mitig`=1. Classes 5, 6 and 7 clear the tracker. Class 8 does not.
- R4: A non-vector instruction with `exec_rd` high, followed later by a vector ALU instruction with `exec_wr` high, gives `hz_code`=4 and `mitig`=1. Two things clear the tracker: a vector ALU instruction with `sreg_wr_en` high, and a class 14 dependency-counter wait with value 0xfffe.
- R5: Two orders give `hz_code`=5 and `mitig`=3 (wait). One is a class 9 access, then a class 2 branch, then a class 11 access. The other is a class 11 access, then a class 2 branch, then a class 9 access. Only a class 14 vector-store wait with value 0 clears the tracker.
- R6: A class 4 store, followed by a class 3 load with the same `smem_addr`, gives `hz_code`=6 and `mitig`=3. Only a class 14 LGKM wait with value 0 clears the tracker. A class 0 NOP does not, and neither does an LGKM wait with a non-zero value.
- R7: A class 2 branch whose `pc_win_off` is all ones (0x3f) gives `hz_code`=7 and `mitig`=4 (NOP).
- R8: When several hazards are found on one instruction, the lowest code is reported first. Each `ack` pulse retires the reported hazard, and the next code appears in the following cycle.
- R9: `hold` depends combinationally on the current descriptor and the stored state. With `in_valid` low, or with no hazard found, `hold`, `hz_code` and `mitig` are all 0.
- R10: A synchronous active-low reset clears every tracker.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Descriptor present |
| in_class | input | 4 | Instruction class code |
| sreg_rd_en | input | 1 | Instruction reads a scalar register |
| sreg_rd_idx | input | SREG_W (8) | Scalar register read (EXEC and M0 have their own indices) |
| sreg_wr_en | input | 1 | Instruction writes a scalar register |
| sreg_wr_idx | input | SREG_W (8) | Scalar register written |
| exec_rd | input | 1 | Instruction reads EXEC |
| exec_wr | input | 1 | Instruction writes EXEC |
| wait_kind | input | 3 | Counter kind waited on (class 14 only) |
| wait_val | input | WVAL_W (16) | Wait operand |
| smem_addr | input | ADDR_W (16) | Scalar buffer address |
| pc_win_off | input | WIN_W (6) | Dword offset within the branch window |
| ack | input | 1 | Retires the reported hazard |
| hold | output | 1 | Stall: a mitigation is needed first |
| hz_code | output | 3 | Hazard code 1 to 7, 0 when none |
| mitig | output | 3 | 0 none, 1 vector ALU, 2 scalar ALU, 3 wait, 4 NOP |

## Verification
One instruction can complete several patterns at once. The bench loads the scalar-read, compare and EXEC-read trackers in sequence. It then presents a single permute that writes both the recorded scalar register and EXEC. The scoreboard expects codes 2, 3 and 4 on successive acknowledged cycles, and then a clean accept. The same approach covers a tracker that is set and reported in one sequence, because each ack must retire only the reported hazard and leave the others still visible.

// File: rtl/hzd_pkg.sv
// Package: shared class codes, wait kinds, mitigation kinds and the decoded
// event record used by the hazard detector. Assumes 4-bit class codes.
package hzd_pkg;

    localparam int NUM_HZ = 7;
    localparam int CODE_W = 3;

    typedef enum logic [3:0] {
        C_SOPP     = 4'd0,
        C_SALU     = 4'd1,
        C_BRANCH   = 4'd2,
        C_SMEM_LD  = 4'd3,
        C_SMEM_ST  = 4'd4,
        C_VALU     = 4'd5,
        C_VOPC     = 4'd6,
        C_PERM     = 4'd7,
        C_VNOP     = 4'd8,
        C_VMEM     = 4'd9,
        C_FLAT     = 4'd10,
        C_DS       = 4'd11,
        C_SETVSKIP = 4'd12,
        C_VERSION  = 4'd13,
        C_WAIT     = 4'd14,
        C_OTHER    = 4'd15
    } cls_e;

    typedef enum logic [2:0] {
        WK_NONE = 3'd0,
        WK_VM   = 3'd1,
        WK_LGKM = 3'd2,
        WK_VS   = 3'd3,
        WK_DEP  = 3'd4
    } wkind_e;

    typedef enum logic [2:0] {
        MIT_NONE = 3'd0,
        MIT_VALU = 3'd1,
        MIT_SALU = 3'd2,
        MIT_WAIT = 3'd3,
        MIT_NOP  = 3'd4
    } mit_e;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_VM   = 2'd1,
        K_DS   = 2'd2
    } lkind_e;

    typedef struct packed {
        logic valu;       // any vector ALU, NOP included
        logic valu_real;  // vector ALU other than vector NOP
        logic nonvalu;
        logic vopc;
        logic perm;
        logic scal_wr;    // scalar ALU or scalar load, may write a scalar reg
        logic salu;       // non-program-control scalar ALU
        logic vm_sreg;    // vector memory / flat / LDS, may read a scalar reg
        logic smem_rd;    // scalar memory, may read a scalar reg
        logic vmem;
        logic ds;
        logic branch;
        logic sst;
        logic sld;
        logic vm0;
        logic lgkm_any;
        logic lgkm0;
        logic vs0;
        logic dep_ok;
    } ev_t;

    // Mitigation kind for a hazard code (1-based, 0 means none).
    function automatic mit_e mit_for(input logic [CODE_W-1:0] code);
        case (code)
            3'd1, 3'd3, 3'd4: mit_for = MIT_VALU;
            3'd2:             mit_for = MIT_SALU;
            3'd5, 3'd6:       mit_for = MIT_WAIT;
            3'd7:             mit_for = MIT_NOP;
            default:          mit_for = MIT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/hzd_decode.sv
// Module: hzd_decode
// Turns the class code and the wait fields into named event flags.
// Purely combinational. Assumes wait fields matter only for the wait class.
module hzd_decode
    import hzd_pkg::*;
#(
    parameter int WVAL_W = 16,
    parameter logic [WVAL_W-1:0] DEP_OK_VAL = WVAL_W'(16'hfffe)
) (
    input  logic [3:0]        cls,
    input  logic [2:0]        wkind,
    input  logic [WVAL_W-1:0] wval,
    output ev_t               ev
);

    cls_e   c;
    wkind_e k;
    logic   is_wait;
    logic   wval_zero;

    // Event flag derivation from class and wait operand
    always_comb begin
        c         = cls_e'(cls);
        k         = wkind_e'(wkind);
        is_wait   = (c == C_WAIT);
        wval_zero = (wval == '0);

        ev.valu      = (c == C_VALU) || (c == C_VOPC) || (c == C_PERM) || (c == C_VNOP);
        ev.valu_real = (c == C_VALU) || (c == C_VOPC) || (c == C_PERM);
        ev.nonvalu   = !ev.valu;
        ev.vopc      = (c == C_VOPC);
        ev.perm      = (c == C_PERM);
        ev.scal_wr   = (c == C_SALU) || (c == C_SMEM_LD);
        ev.salu      = (c == C_SALU);
        ev.vm_sreg   = (c == C_VMEM) || (c == C_FLAT) || (c == C_DS);
        ev.smem_rd   = (c == C_SMEM_LD) || (c == C_SMEM_ST);
        ev.vmem      = (c == C_VMEM);
        ev.ds        = (c == C_DS);
        ev.branch    = (c == C_BRANCH);
        ev.sst       = (c == C_SMEM_ST);
        ev.sld       = (c == C_SMEM_LD);
        ev.vm0       = is_wait && (k == WK_VM) && wval_zero;
        ev.lgkm_any  = is_wait && (k == WK_LGKM);
        ev.lgkm0     = is_wait && (k == WK_LGKM) && wval_zero;
        ev.vs0       = is_wait && (k == WK_VS) && wval_zero;
        ev.dep_ok    = is_wait && (k == WK_DEP) && (wval == DEP_OK_VAL);
    end

endmodule

// File: rtl/hzd_pending.sv
// Module: hzd_pending
// Keeps one pending tracker per hazard class and flags which hazards the
// current descriptor completes. Assumes the descriptor stays stable while
// it is stalled. State changes on an accepted instruction (clears are
// applied first, then sets) or on an acknowledge of the reported hazard.
module hzd_pending
    import hzd_pkg::*;
#(
    parameter int SREG_W = 8,
    parameter int ADDR_W = 16,
    parameter int WIN_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              accept,
    input  ev_t               ev,
    input  logic              sreg_rd_en,
    input  logic [SREG_W-1:0] sreg_rd_idx,
    input  logic              sreg_wr_en,
    input  logic [SREG_W-1:0] sreg_wr_idx,
    input  logic              exec_rd,
    input  logic              exec_wr,
    input  logic [ADDR_W-1:0] smem_addr,
    input  logic [WIN_W-1:0]  pc_win_off,
    input  logic [NUM_HZ-1:0] ack_clr,
    output logic [NUM_HZ-1:0] hit
);

    localparam logic [WIN_W-1:0] BAD_OFF = '1;

    logic              h1_v, h2_v, h3_v, h4_v, h6_v, h5_br, br_ack;
    logic [SREG_W-1:0] h1_idx, h2_idx;
    logic [ADDR_W-1:0] h6_addr;
    lkind_e            h5_kind;

    // Hazard hit vector for the presented descriptor
    always_comb begin
        hit[0] = in_valid && h1_v && ev.scal_wr && sreg_wr_en && (sreg_wr_idx == h1_idx);
        hit[1] = in_valid && h2_v && ev.valu && sreg_wr_en && (sreg_wr_idx == h2_idx);
        hit[2] = in_valid && h3_v && ev.perm;
        hit[3] = in_valid && h4_v && ev.valu && exec_wr;
        hit[4] = in_valid && h5_br && ((h5_kind == K_VM && ev.ds) || (h5_kind == K_DS && ev.vmem));
        hit[5] = in_valid && h6_v && ev.sld && (smem_addr == h6_addr);
        hit[6] = in_valid && ev.branch && (pc_win_off == BAD_OFF) && !br_ack;
    end

    // Vector-memory read then scalar write tracker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h1_v <= 1'b0; h1_idx <= '0;
        end else if (ack_clr[0]) begin
            h1_v <= 1'b0;
        end else if (accept) begin
            if (ev.vm_sreg && sreg_rd_en) begin
                h1_v <= 1'b1; h1_idx <= sreg_rd_idx;
            end else if (ev.valu || ev.vm0) begin
                h1_v <= 1'b0;
            end
        end
    end

    // Scalar-memory read then vector write tracker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h2_v <= 1'b0; h2_idx <= '0;
        end else if (ack_clr[1]) begin
            h2_v <= 1'b0;
        end else if (accept) begin
            if (ev.smem_rd && sreg_rd_en) begin
                h2_v <= 1'b1; h2_idx <= sreg_rd_idx;
            end else if (ev.salu || ev.lgkm_any) begin
                h2_v <= 1'b0;
            end
        end
    end

    // Compare then permute tracker
    always_ff @(posedge clk) begin
        if (!rst_n)           h3_v <= 1'b0;
        else if (ack_clr[2])  h3_v <= 1'b0;
        else if (accept) begin
            if (ev.vopc)           h3_v <= 1'b1;
            else if (ev.valu_real) h3_v <= 1'b0;
        end
    end

    // EXEC read by non-vector then written by vector tracker
    always_ff @(posedge clk) begin
        if (!rst_n)           h4_v <= 1'b0;
        else if (ack_clr[3])  h4_v <= 1'b0;
        else if (accept) begin
            if (ev.nonvalu && exec_rd)                    h4_v <= 1'b1;
            else if ((ev.valu && sreg_wr_en) || ev.dep_ok) h4_v <= 1'b0;
        end
    end

    // Memory kind / branch / other memory kind sequence tracker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h5_kind <= K_NONE; h5_br <= 1'b0;
        end else if (ack_clr[4]) begin
            h5_kind <= K_NONE; h5_br <= 1'b0;
        end else if (accept) begin
            if (ev.vs0) begin
                h5_kind <= K_NONE; h5_br <= 1'b0;
            end else if (ev.vmem) begin
                h5_kind <= K_VM; h5_br <= 1'b0;
            end else if (ev.ds) begin
                h5_kind <= K_DS; h5_br <= 1'b0;
            end else if (ev.branch && h5_kind != K_NONE) begin
                h5_br <= 1'b1;
            end
        end
    end

    // Scalar buffer store then load to the same address tracker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h6_v <= 1'b0; h6_addr <= '0;
        end else if (ack_clr[5]) begin
            h6_v <= 1'b0;
        end else if (accept) begin
            if (ev.sst) begin
                h6_v <= 1'b1; h6_addr <= smem_addr;
            end else if (ev.lgkm0) begin
                h6_v <= 1'b0;
            end
        end
    end

    // Marks the stalled branch whose window offset was already padded
    always_ff @(posedge clk) begin
        if (!rst_n)          br_ack <= 1'b0;
        else if (ack_clr[6]) br_ack <= 1'b1;
        else if (accept)     br_ack <= 1'b0;
    end

    AST_SET_VM_SREG: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ev.vm_sreg && sreg_rd_en) |=> h1_v) else $error("set"); // R1
    AST_ACK_DROPS_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        ack_clr[2] |=> !h3_v) else $error("ack"); // R3
    AST_VSWAIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ev.vs0) |=> (h5_kind == K_NONE && !h5_br)) else $error("vs"); // R5
    AST_NO_ACCEPT_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (hit == '0)) else $error("accept"); // R9

endmodule

// File: rtl/hzd_arbiter.sv
// Module: hzd_arbiter
// Picks the lowest-numbered hazard hit, drives hold, the code and the
// mitigation kind, and turns an acknowledge into a one-hot tracker clear.
module hzd_arbiter
    import hzd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_HZ-1:0] hit,
    input  logic              ack,
    output logic              hold,
    output logic [CODE_W-1:0] code,
    output logic [2:0]        mit,
    output logic [NUM_HZ-1:0] ack_clr
);

    logic [NUM_HZ:0]   blocked;
    logic [NUM_HZ-1:0] grant;

    assign blocked[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_HZ; gi++) begin : g_prio
            assign grant[gi]       = hit[gi] && !blocked[gi];
            assign blocked[gi + 1] = blocked[gi] || hit[gi];
        end
    endgenerate

    // Encode the granted hazard and its mitigation
    always_comb begin
        code = '0;
        for (int i = 0; i < NUM_HZ; i++) begin
            if (grant[i]) code = CODE_W'(i + 1);
        end
        mit     = mit_for(code);
        hold    = blocked[NUM_HZ];
        ack_clr = grant & {NUM_HZ{ack}};
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)) else $error("grant"); // R8
    AST_HOLD_HAS_MIT: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (mit != MIT_NONE && code != '0)) else $error("mit"); // R8

endmodule

// File: rtl/shader_hazard_guard.sv
// Module: shader_hazard_guard
// Top of the ordering hazard detector: decode, per-class trackers and
// priority report. Assumes the upstream stalls while hold is high and keeps
// the descriptor unchanged until it is accepted.
module shader_hazard_guard
    import hzd_pkg::*;
#(
    parameter int SREG_W = 8,
    parameter int ADDR_W = 16,
    parameter int WVAL_W = 16,
    parameter int WIN_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        in_class,
    input  logic              sreg_rd_en,
    input  logic [SREG_W-1:0] sreg_rd_idx,
    input  logic              sreg_wr_en,
    input  logic [SREG_W-1:0] sreg_wr_idx,
    input  logic              exec_rd,
    input  logic              exec_wr,
    input  logic [2:0]        wait_kind,
    input  logic [WVAL_W-1:0] wait_val,
    input  logic [ADDR_W-1:0] smem_addr,
    input  logic [WIN_W-1:0]  pc_win_off,
    input  logic              ack,
    output logic              hold,
    output logic [2:0]        hz_code,
    output logic [2:0]        mitig
);

    ev_t               ev;
    logic [NUM_HZ-1:0] hit;
    logic [NUM_HZ-1:0] ack_clr;
    logic              accept;

    assign accept = in_valid && !hold;

    hzd_decode #(.WVAL_W(WVAL_W)) u_decode (
        .cls   (in_class),
        .wkind (wait_kind),
        .wval  (wait_val),
        .ev    (ev)
    );

    hzd_pending #(.SREG_W(SREG_W), .ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_pending (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .accept      (accept),
        .ev          (ev),
        .sreg_rd_en  (sreg_rd_en),
        .sreg_rd_idx (sreg_rd_idx),
        .sreg_wr_en  (sreg_wr_en),
        .sreg_wr_idx (sreg_wr_idx),
        .exec_rd     (exec_rd),
        .exec_wr     (exec_wr),
        .smem_addr   (smem_addr),
        .pc_win_off  (pc_win_off),
        .ack_clr     (ack_clr),
        .hit         (hit)
    );

    hzd_arbiter u_arbiter (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .ack     (ack),
        .hold    (hold),
        .code    (hz_code),
        .mit     (mitig),
        .ack_clr (ack_clr)
    );

endmodule

// File: tb/shader_hazard_guard_tb.sv
// Scoreboard bench: the driver stages a descriptor, pushes the expected
// hazard code, and the monitor compares code, mitigation and hold.
module shader_hazard_guard_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_class = '0;
    logic        sreg_rd_en = 1'b0, sreg_wr_en = 1'b0;
    logic [7:0]  sreg_rd_idx = '0, sreg_wr_idx = '0;
    logic        exec_rd = 1'b0, exec_wr = 1'b0;
    logic [2:0]  wait_kind = '0;
    logic [15:0] wait_val = '0;
    logic [15:0] smem_addr = '0;
    logic [5:0]  pc_win_off = '0;
    logic        ack = 1'b0;
    logic        hold;
    logic [2:0]  hz_code, mitig;

    // staged descriptor
    logic        s_valid;
    logic [3:0]  s_cls;
    logic        s_rde, s_wre, s_exr, s_exw;
    logic [7:0]  s_rdi, s_wri;
    logic [2:0]  s_wk;
    logic [15:0] s_wv, s_addr;
    logic [5:0]  s_pc;

    int    checks = 0;
    int    failures = 0;
    bit    done = 0;
    int    q_code[$];
    string q_tag[$];
    event  chk_ev;

    always #2 clk = ~clk;

    shader_hazard_guard u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .sreg_rd_en(sreg_rd_en), .sreg_rd_idx(sreg_rd_idx),
        .sreg_wr_en(sreg_wr_en), .sreg_wr_idx(sreg_wr_idx),
        .exec_rd(exec_rd), .exec_wr(exec_wr), .wait_kind(wait_kind),
        .wait_val(wait_val), .smem_addr(smem_addr), .pc_win_off(pc_win_off),
        .ack(ack), .hold(hold), .hz_code(hz_code), .mitig(mitig)
    );

    function automatic int exp_mit(input int code);
        case (code)
            1, 3, 4: return 1;
            2:       return 2;
            5, 6:    return 3;
            7:       return 4;
            default: return 0;
        endcase
    endfunction

    // Monitor: pop expected item and compare with the outputs
    always @(chk_ev) begin
        int    ec;
        string tg;
        ec = q_code.pop_front();
        tg = q_tag.pop_front();
        checks++;
        if (int'(hz_code) != ec || int'(mitig) != exp_mit(ec) || hold != (ec != 0)) begin
            failures++;
            $display("FAIL %s: code=%0d mit=%0d hold=%0d expected code=%0d mit=%0d hold=%0d",
                     tg, hz_code, mitig, hold, ec, exp_mit(ec), (ec != 0));
        end
    end

    task automatic ins(input int c);
        s_valid = 1'b1; s_cls = 4'(c);
        s_rde = 0; s_wre = 0; s_exr = 0; s_exw = 0;
        s_rdi = '0; s_wri = '0; s_wk = '0; s_wv = '0; s_addr = '0; s_pc = '0;
    endtask

    // Drive the staged descriptor for one cycle and expect a code
    task automatic go(input int code, input bit a, input string tag);
        @(negedge clk);
        in_valid = s_valid; in_class = s_cls;
        sreg_rd_en = s_rde; sreg_rd_idx = s_rdi;
        sreg_wr_en = s_wre; sreg_wr_idx = s_wri;
        exec_rd = s_exr; exec_wr = s_exw;
        wait_kind = s_wk; wait_val = s_wv;
        smem_addr = s_addr; pc_win_off = s_pc; ack = a;
        #1;
        q_code.push_back(code);
        q_tag.push_back(tag);
        -> chk_ev;
        #0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; ack = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        ins(0); s_valid = 0; go(0, 0, "R9 idle after reset");

        // R10: reset drops a pending compare
        ins(6); go(0, 0, "R3 compare");
        do_reset();
        ins(7); go(0, 0, "R10 permute after reset");

        // R1
        do_reset();
        ins(11); s_rde = 1; s_rdi = 8'd5; go(0, 0, "R1 LDS reads s5");
        ins(1); s_wre = 1; s_wri = 8'd5; go(1, 1, "R1 scalar write s5");
        go(0, 0, "R1 after ack");
        ins(9); s_rde = 1; s_rdi = 8'd7; go(0, 0, "R1 vmem reads s7");
        ins(5); go(0, 0, "R1 valu");
        ins(1); s_wre = 1; s_wri = 8'd7; go(0, 0, "R1 cleared by valu");
        ins(10); s_rde = 1; s_rdi = 8'd9; go(0, 0, "R1 flat reads s9");
        ins(14); s_wk = 3'd1; go(0, 0, "R1 vm wait 0");
        ins(3); s_wre = 1; s_wri = 8'd9; go(0, 0, "R1 cleared by vm wait");
        ins(9); s_rde = 1; s_rdi = 8'd3; go(0, 0, "R1 vmem reads s3");
        ins(1); s_wre = 1; s_wri = 8'd4; go(0, 0, "R1 other register");

        // R2
        do_reset();
        ins(3); s_rde = 1; s_rdi = 8'd10; go(0, 0, "R2 smem reads s10");
        ins(12); go(0, 0, "R2 setvskip");
        ins(13); go(0, 0, "R2 version");
        ins(14); s_wk = 3'd1; go(0, 0, "R2 vm wait");
        ins(0); go(0, 0, "R2 program control");
        ins(5); s_wre = 1; s_wri = 8'd10; go(2, 1, "R2 valu writes s10");
        go(0, 0, "R2 after ack");
        ins(3); s_rde = 1; s_rdi = 8'd11; go(0, 0, "R2 smem reads s11");
        ins(1); go(0, 0, "R2 salu");
        ins(5); s_wre = 1; s_wri = 8'd11; go(0, 0, "R2 cleared by salu");
        ins(4); s_rde = 1; s_rdi = 8'd12; go(0, 0, "R2 store reads s12");
        ins(14); s_wk = 3'd2; s_wv = 16'd3; go(0, 0, "R2 lgkm wait 3");
        ins(5); s_wre = 1; s_wri = 8'd12; go(0, 0, "R2 cleared by lgkm wait");

        // R3
        do_reset();
        ins(6); go(0, 0, "R3 compare");
        ins(8); go(0, 0, "R3 vector nop");
        ins(7); go(3, 1, "R3 permute after nop");
        go(0, 0, "R3 after ack");
        ins(6); go(0, 0, "R3 compare");
        ins(5); go(0, 0, "R3 valu");
        ins(7); go(0, 0, "R3 cleared by valu");

        // R4
        do_reset();
        ins(1); s_exr = 1; go(0, 0, "R4 salu reads exec");
        ins(5); s_exw = 1; go(4, 1, "R4 valu writes exec");
        go(0, 0, "R4 after ack");
        ins(1); s_exr = 1; go(0, 0, "R4 salu reads exec");
        ins(5); s_wre = 1; s_wri = 8'd20; go(0, 0, "R4 valu with sdst");
        ins(5); s_exw = 1; go(0, 0, "R4 cleared by sdst valu");
        ins(1); s_exr = 1; go(0, 0, "R4 salu reads exec");
        ins(14); s_wk = 3'd4; s_wv = 16'hfffe; go(0, 0, "R4 depctr wait");
        ins(5); s_exw = 1; go(0, 0, "R4 cleared by depctr");

        // R5
        do_reset();
        ins(9); go(0, 0, "R5 vmem");
        ins(2); go(0, 0, "R5 branch");
        ins(11); go(5, 1, "R5 LDS after branch");
        go(0, 0, "R5 after ack");
        ins(2); s_pc = 6'd1; go(0, 0, "R5 branch after LDS");
        ins(9); go(5, 1, "R5 vmem after branch");
        go(0, 0, "R5 after ack");
        ins(14); s_wk = 3'd3; go(0, 0, "R5 vs wait 0");
        ins(2); go(0, 0, "R5 branch");
        ins(11); go(0, 0, "R5 cleared by vs wait");

        // R6
        do_reset();
        ins(4); s_addr = 16'h40; go(0, 0, "R6 store 0x40");
        ins(0); go(0, 0, "R6 nop");
        ins(3); s_addr = 16'h40; go(6, 1, "R6 load 0x40");
        go(0, 0, "R6 after ack");
        ins(4); s_addr = 16'h50; go(0, 0, "R6 store 0x50");
        ins(14); s_wk = 3'd2; s_wv = 16'd1; go(0, 0, "R6 lgkm wait 1");
        ins(3); s_addr = 16'h50; go(6, 1, "R6 load after nonzero wait");
        go(0, 0, "R6 after ack");
        ins(4); s_addr = 16'h60; go(0, 0, "R6 store 0x60");
        ins(14); s_wk = 3'd2; go(0, 0, "R6 lgkm wait 0");
        ins(3); s_addr = 16'h60; go(0, 0, "R6 cleared by lgkm wait 0");
        ins(4); s_addr = 16'h70; go(0, 0, "R6 store 0x70");
        ins(3); s_addr = 16'h74; go(0, 0, "R6 different address");

        // R7
        do_reset();
        ins(2); s_pc = 6'h3f; go(7, 1, "R7 branch at 0x3f");
        go(0, 0, "R7 after ack");
        ins(2); s_pc = 6'h3e; go(0, 0, "R7 branch at 0x3e");

        // R8: three hazards on one permute
        do_reset();
        ins(3); s_rde = 1; s_rdi = 8'd30; go(0, 0, "R8 smem reads s30");
        ins(6); go(0, 0, "R8 compare");
        ins(2); s_exr = 1; s_pc = 6'h10; go(0, 0, "R8 branch reads exec");
        ins(7); s_wre = 1; s_wri = 8'd30; s_exw = 1; go(2, 1, "R8 first code");
        go(3, 1, "R8 second code");
        go(4, 1, "R8 third code");
        go(0, 0, "R8 all retired");

        // R9: invalid descriptor raises nothing
        do_reset();
        ins(6); go(0, 0, "R9 compare");
        ins(7); s_valid = 0; go(0, 0, "R9 permute not valid");
        s_valid = 1; go(3, 1, "R9 permute valid");
        go(0, 0, "R9 after ack");

        @(negedge clk);
        in_valid = 1'b0;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule